// File: doc/BRIEF.md
# Register-Programmed SPI Flash Command Engine

This block lets a host issue one short command to a SPI flash device by programming a small bank of byte-wide registers. The host loads an opcode byte and up to three payload bytes. It then writes a control byte that packs three fields: how many payload bytes follow the opcode, how many response bytes to collect, and a command class. Setting the start bit in that control byte launches the transfer. The host polls the same bit until it reads back as zero.

On the serial side the engine is a mode-0 SPI master. It lowers the chip select, shifts out the opcode and the requested payload bytes MSB first, and then keeps clocking while it captures the requested number of response bytes from MISO. It raises the chip select when the last bit is done. The received bytes land in consecutive response registers, where the host reads them back through the same byte register bus. The serial clock is the system clock divided by a parameter.

Top module: `spi_cmd_engine`

## Requirements
- R1: Register offsets: control at 0x60, opcode at 0x61, payload bytes 0..2 at 0x64..0x66, response bytes 0..2 at 0x67..0x69. Opcode and payload registers read back the value last written.
- R2: Control byte layout: bit 0 start/busy, bits 4:3 payload byte count W (0 to 3), bits 2:1 response byte count R (0 to 3), bits 7:5 command class. Bits 7:1 read back as written. The class has no effect on the serial lines, and a control write with bit 0 clear starts nothing.
- R3: A transfer produces exactly 8*(1+W+R) SCK pulses. The MOSI stream is the opcode followed by payload bytes 0..W-1, MSB first, and MOSI is low while response bits are clocked.
- R4: Control bit 0 reads 1 from the launch until the transfer ends and 0 afterwards. CS_n is low exactly while the engine is busy.
- R5: Response bits are sampled only after all 8*(1+W) transmit bits. The first received byte is stored at 0x67 and later bytes at the following offsets.
- R6: SCK idles low and pulses only while CS_n is low. CS_n falls SCK_HALF system cycles before the first SCK rising edge and rises SCK_HALF cycles after the last SCK falling edge.
- R7: While busy, writes to the control, opcode and payload registers are ignored. This includes a control write with bit 0 set, which does not start a second transfer.
- R8: A response register whose index is not below R keeps its previous value.
- R9: Mode 0: MOSI changes only while SCK is low, and MISO is sampled on the SCK rising edge.
- R10: Each SCK high phase lasts SCK_HALF system cycles.
- R11: Read data appears on the cycle after the read strobe. Unmapped offsets read 0, and after reset every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, valid one cycle after reg_re |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
A write strobe takes effect at the following clock edge, and read data is due one cycle after the read strobe. The bench therefore drives at falling clock edges and samples read data at the next falling edge. On the serial side, each line transition is registered at a system clock edge: the first SCK rise comes SCK_HALF cycles after CS_n falls, each bit takes 2*SCK_HALF cycles, and CS_n rises SCK_HALF cycles after the last fall. The bench's line monitor counts falling clock edges between these transitions and compares the counts with SCK_HALF. Response registers and the busy bit change on the same edge that raises CS_n, so the bench reads them only after polling shows bit 0 clear.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam logic [7:0] ADDR_CTRL = 8'h60;
    localparam logic [7:0] ADDR_OPC  = 8'h61;
    localparam logic [7:0] ADDR_PAY  = 8'h64;
    localparam logic [7:0] ADDR_RESP = 8'h67;

    localparam int PAY_MAX  = 3;
    localparam int RESP_MAX = 3;
    localparam int TX_W     = 8 * (1 + PAY_MAX);
    localparam int RX_W     = 8 * RESP_MAX;
    localparam int BIT_W    = $clog2(TX_W + RX_W + 1);

    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_RUN  = 2'd1,
        SH_TAIL = 2'd2
    } sh_state_e;

    typedef struct packed {
        logic [7:1]                ctrl;
        logic [7:0]                opc;
        logic [PAY_MAX-1:0][7:0]   pay;
        logic [RESP_MAX-1:0][7:0]  resp;
        logic                      busy;
        logic [7:0]                rdata;
    } bank_t;

    typedef struct packed {
        sh_state_e         st;
        logic              sck;
        logic [TX_W-1:0]   tx;
        logic [RX_W-1:0]   rx;
        logic [BIT_W-1:0]  bit_idx;
        logic [BIT_W-1:0]  last_bit;
        logic [BIT_W-1:0]  tx_bits;
        logic [1:0]        rcnt;
    } shift_t;
endpackage

// File: rtl/spi_cmd_clkdiv.sv
module spi_cmd_clkdiv #(
    parameter int SCK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam logic [CW-1:0] TOP = CW'(SCK_HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == TOP);
        cnt_d = cnt_q;
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
    import spi_cmd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            launch,
    input  logic [1:0]      wcnt,
    input  logic [1:0]      rcnt,
    input  logic [TX_W-1:0] tx_word,
    input  logic            miso,
    output logic            sck,
    output logic            mosi,
    output logic            cs_n,
    output logic            active,
    output logic            fin,
    output logic [RX_W-1:0] rx_aligned
);
    shift_t q, d;

    always_comb begin
        d   = q;
        fin = 1'b0;
        case (q.st)
            SH_IDLE: begin
                if (launch) begin
                    d.st       = SH_RUN;
                    d.sck      = 1'b0;
                    d.tx_bits  = BIT_W'({wcnt, 3'b000}) + BIT_W'(8);
                    d.tx       = tx_word & ~({TX_W{1'b1}} >> d.tx_bits);
                    d.rx       = '0;
                    d.bit_idx  = '0;
                    d.last_bit = BIT_W'({wcnt, 3'b000}) + BIT_W'({rcnt, 3'b000}) + BIT_W'(7);
                    d.rcnt     = rcnt;
                end
            end
            SH_RUN: begin
                if (tick) begin
                    if (!q.sck) begin
                        d.sck = 1'b1;
                        if (q.bit_idx >= q.tx_bits) d.rx = {q.rx[RX_W-2:0], miso};
                    end else begin
                        d.sck = 1'b0;
                        d.tx  = q.tx << 1;
                        if (q.bit_idx == q.last_bit) d.st = SH_TAIL;
                        else                         d.bit_idx = q.bit_idx + 1'b1;
                    end
                end
            end
            SH_TAIL: begin
                if (tick) begin
                    d.st = SH_IDLE;
                    fin  = 1'b1;
                end
            end
            default: d.st = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck        = q.sck;
    assign mosi       = q.tx[TX_W-1];
    assign cs_n       = (q.st == SH_IDLE);
    assign active     = (q.st != SH_IDLE);
    assign rx_aligned = q.rx << {2'd3 - q.rcnt, 3'b000};
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int SCK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic       reg_we,
    input  logic       reg_re,
    output logic [7:0] reg_rdata,
    output logic       spi_sck,
    output logic       spi_mosi,
    input  logic       spi_miso,
    output logic       spi_cs_n
);
    bank_t q, d;

    logic            launch;
    logic            tick;
    logic            active;
    logic            fin;
    logic [RX_W-1:0] rx_aligned;
    logic [TX_W-1:0] tx_word;
    logic [7:0]      rd_mux;
    logic            busy;
    logic [7:0]      opc_held;

    always_comb begin
        tx_word = '0;
        tx_word[TX_W-1 -: 8] = q.opc;
        for (int i = 0; i < PAY_MAX; i++) tx_word[TX_W-9-8*i -: 8] = q.pay[i];
    end

    always_comb begin
        rd_mux = 8'h00;
        if (reg_addr == ADDR_CTRL) rd_mux = {q.ctrl, q.busy};
        if (reg_addr == ADDR_OPC)  rd_mux = q.opc;
        for (int i = 0; i < PAY_MAX; i++)
            if (reg_addr == ADDR_PAY + 8'(i)) rd_mux = q.pay[i];
        for (int k = 0; k < RESP_MAX; k++)
            if (reg_addr == ADDR_RESP + 8'(k)) rd_mux = q.resp[k];
    end

    always_comb begin
        d      = q;
        launch = 1'b0;
        if (reg_we && !q.busy) begin
            if (reg_addr == ADDR_CTRL) begin
                d.ctrl = reg_wdata[7:1];
                launch = reg_wdata[0];
                d.busy = reg_wdata[0];
            end
            if (reg_addr == ADDR_OPC) d.opc = reg_wdata;
            for (int i = 0; i < PAY_MAX; i++)
                if (reg_addr == ADDR_PAY + 8'(i)) d.pay[i] = reg_wdata;
        end
        if (fin) begin
            d.busy = 1'b0;
            for (int k = 0; k < RESP_MAX; k++)
                if (2'(k) < q.ctrl[2:1]) d.resp[k] = rx_aligned[RX_W-1-8*k -: 8];
        end
        if (reg_re) d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    spi_cmd_clkdiv #(.SCK_HALF(SCK_HALF)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (active),
        .tick  (tick)
    );

    spi_cmd_shifter u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .launch     (launch),
        .wcnt       (reg_wdata[4:3]),
        .rcnt       (reg_wdata[2:1]),
        .tx_word    (tx_word),
        .miso       (spi_miso),
        .sck        (spi_sck),
        .mosi       (spi_mosi),
        .cs_n       (spi_cs_n),
        .active     (active),
        .fin        (fin),
        .rx_aligned (rx_aligned)
    );

    assign reg_rdata = q.rdata;
    assign busy      = q.busy;
    assign opc_held  = q.opc;
endmodule

// File: rtl/spi_cmd_checker.sv
module spi_cmd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sck,
    input logic       cs_n,
    input logic       mosi,
    input logic       busy,
    input logic [7:0] opc
);
    AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n) sck |-> !cs_n); // R6
    AST_BUSY_TRACKS_CS: assert property (@(posedge clk) disable iff (!rst_n) busy == !cs_n); // R4
    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (sck && $past(sck)) |-> $stable(mosi)); // R9
    AST_OPC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(opc)); // R7
    AST_CS_RISE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |-> (!sck && !$past(sck))); // R6
endmodule

bind spi_cmd_engine spi_cmd_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sck   (spi_sck),
    .cs_n  (spi_cs_n),
    .mosi  (spi_mosi),
    .busy  (busy),
    .opc   (opc_held)
);

// File: tb/tb_spi_cmd_engine.sv
module tb_spi_cmd_engine;
    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic       reg_we = 1'b0;
    logic       reg_re = 1'b0;
    logic [7:0] reg_rdata;
    logic       spi_sck, spi_mosi, spi_miso, spi_cs_n;

    spi_cmd_engine #(.SCK_HALF(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    // 50 MHz: 20 ns period
    initial forever #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    // line monitor and flash responder, all at falling clock edges
    int          cyc = 0;
    logic        prev_sck = 1'b0, prev_cs = 1'b1;
    logic [63:0] mosi_cap;
    int          nrise, n_cs_fall;
    int          c_cs_fall, c_first_rise, c_last_fall, c_cs_rise, c_rise;
    bit          high_ok;
    int          idx;
    logic [55:0] slv_stream;

    assign spi_miso = (idx < 56) ? slv_stream[55 - idx] : 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (prev_cs && !spi_cs_n) begin c_cs_fall = cyc; idx = 0; n_cs_fall++; end
        if (!prev_cs && spi_cs_n) c_cs_rise = cyc;
        if (spi_sck && !prev_sck) begin
            mosi_cap = {mosi_cap[62:0], spi_mosi};
            if (nrise == 0) c_first_rise = cyc;
            nrise++;
            c_rise = cyc;
        end
        if (!spi_sck && prev_sck) begin
            c_last_fall = cyc;
            if (cyc - c_rise != HALF) high_ok = 0;
            idx++;
        end
        prev_sck = spi_sck;
        prev_cs  = spi_cs_n;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        @(negedge clk);
        reg_re = 1'b0;
        v = reg_rdata;
    endtask

    function automatic logic [7:0] sbyte(input int seed, input int j);
        return 8'(seed * 37 + j * 29 + 8'h5A);
    endfunction

    logic [7:0] model_resp [0:2];

    task automatic run(input int cls, input int w, input int r, input int seed, input bit inject);
        logic [7:0] opc, v;
        logic [7:0] p [0:2];
        logic [7:0] ctrl;
        logic [63:0] exp64;
        int nbits, polls, falls0;
        opc  = 8'(seed * 11 + 3);
        for (int i = 0; i < 3; i++) p[i] = 8'(seed * 53 + i * 17 + 1);
        ctrl = {3'(cls), 2'(w), 2'(r), 1'b0};
        for (int i = 0; i < 3; i++) wr(8'h64 + 8'(i), p[i]);
        wr(8'h61, opc);
        falls0 = n_cs_fall;
        wr(8'h60, ctrl);
        repeat (3) @(negedge clk);
        chk(n_cs_fall == falls0 && spi_cs_n, "R2 no launch with bit0 clear", 64'(n_cs_fall - falls0), 0);
        for (int j = 0; j < 7; j++) slv_stream[55 - 8*j -: 8] = sbyte(seed, j);
        @(posedge clk);
        mosi_cap = 0; nrise = 0; high_ok = 1; idx = 99;
        wr(8'h60, ctrl | 8'h01);
        if (inject) begin
            wr(8'h61, ~opc);
            wr(8'h64, ~p[0]);
            wr(8'h60, ~ctrl | 8'h01);
        end
        rd(8'h60, v);
        chk(v[0] == 1'b1, "R4 busy reads 1", 64'(v), 64'(ctrl | 8'h01));
        polls = 0;
        while (v[0] && polls < 1000) begin rd(8'h60, v); polls++; end
        chk(v == ctrl, "R4/R2 ctrl after done", 64'(v), 64'(ctrl));
        repeat (4 * HALF) @(negedge clk);
        nbits = 8 * (1 + w + r);
        chk(nrise == nbits, "R3 sck pulse count", 64'(nrise), 64'(nbits));
        chk(n_cs_fall == falls0 + 1, "R7 single transfer", 64'(n_cs_fall - falls0), 1);
        exp64 = {opc, p[0], p[1], p[2], 32'h0};
        exp64 &= ~(64'hFFFF_FFFF_FFFF_FFFF >> (8 * (1 + w)));
        exp64 = exp64 >> (64 - nbits);
        chk(mosi_cap == exp64, "R3/R9 mosi stream", mosi_cap, exp64);
        chk(c_first_rise - c_cs_fall == HALF, "R6 cs lead", 64'(c_first_rise - c_cs_fall), HALF);
        chk(c_cs_rise - c_last_fall == HALF, "R6 cs lag", 64'(c_cs_rise - c_last_fall), HALF);
        chk(high_ok, "R10 sck high time", 64'(high_ok), 1);
        for (int k = 0; k < r; k++) model_resp[k] = sbyte(seed, 1 + w + k);
        for (int k = 0; k < 3; k++) begin
            rd(8'h67 + 8'(k), v);
            chk(v == model_resp[k], (k < r) ? "R5 response byte" : "R8 unrequested kept",
                64'(v), 64'(model_resp[k]));
        end
        rd(8'h61, v);
        chk(v == opc, "R1/R7 opcode readback", 64'(v), 64'(opc));
        rd(8'h64, v);
        chk(v == p[0], "R1/R7 payload readback", 64'(v), 64'(p[0]));
    endtask

    initial begin
        logic [7:0] v;
        idx = 99; nrise = 0; n_cs_fall = 0; high_ok = 1; mosi_cap = 0; slv_stream = 0;
        c_cs_fall = 0; c_first_rise = 0; c_last_fall = 0; c_cs_rise = 0; c_rise = 0;
        for (int k = 0; k < 3; k++) model_resp[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R11 reset lines", {spi_cs_n, spi_sck}, 2'b10);
        rd(8'h60, v);
        chk(v == 8'h00, "R11 reset ctrl", 64'(v), 0);
        rd(8'h67, v);
        chk(v == 8'h00, "R11 reset response", 64'(v), 0);
        rd(8'h62, v);
        chk(v == 8'h00, "R11 unmapped reads 0", 64'(v), 0);
        for (int pass = 0; pass < 2; pass++)
            for (int w = 0; w < 4; w++)
                for (int r = 0; r < 4; r++) begin
                    int cls;
                    cls = ((w + r + pass) % 3 == 0) ? 2 : (((w + r + pass) % 3 == 1) ? 3 : 5);
                    run(cls, w, r, pass * 16 + w * 4 + r + 1, pass == 1);
                end
        rd(8'h63, v);
        chk(v == 8'h00, "R11 unmapped reads 0", 64'(v), 0);
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule